// File: doc/BRIEF.md
# Multiplexed-Bus Machine Cycle Generator

This block runs one bus machine cycle at a time for an 8-bit processor whose low address byte and data share a single set of pins. A requester picks a cycle kind: opcode fetch (short or long), memory read, memory write, IO read or IO write. It supplies a 16-bit address and, for writes, a data byte. The generator then steps through its T-states. It drives the address-latch strobe, the read and write strobes, the IO/memory select, the two status bits, the shared low bus with its output enable, and the separate high address bus. It samples the ready input and hands back the byte it read.

The sequencer is an enumerated state machine with states IDLE, T1, T2, TW (wait), T3, T4, T5 and T6. It has these transitions:
- IDLE to T1 on an accepted request.
- T1 to T2.
- T2 or TW to TW while ready is low.
- T2 or TW to T3 once ready is high.
- T3 to IDLE for read and write cycles, or T3 to T4 for a fetch.
- T4 to IDLE for a short fetch, or T4 to T5 for a long fetch.
- T5 to T6, then T6 to IDLE.

The cycle in which the machine is back in IDLE after the last T-state carries the done pulse. For a write, that same cycle also carries one extra clock of write-data hold.

Top module: `bus_cycle_engine`

## Requirements
- R1: The status pair {s1,s0} reads 2'b11 in every T-state of a fetch, 2'b10 in every T-state of a memory or IO read, 2'b01 in every T-state of a memory or IO write, and 2'b00 whenever the block is idle.
- R2: io_m is 1 in every T-state of an IO read or IO write. It is 0 during fetches, memory cycles and idle.
- R3: In T1, ale is 1, ad_oe is 1 and ad_o carries address bits [7:0]. In every other cycle ale is 0.
- R4: a_hi carries address bits [15:8] in every cycle from T1 up to and including the last T-state.
- R5: For fetch and read cycles, rd_n is 0 in T2, in every wait state and in T3, and 1 everywhere else. ad_oe is 0 from T2 until the cycle ends.
- R6: For write cycles, wr_n is 0 in T2, in every wait state and in T3, and 1 everywhere else. ad_o carries the write byte with ad_oe at 1 from T2 through T3 and for one further clock after T3.
- R7: When ready is 0 at the clock edge ending T2 or a wait state, a further wait state follows and the active strobe stays low. T3 follows the first edge that sees ready at 1.
- R8: A fetch adds T4 after T3, with both strobes high and ad_oe at 0. If req_long was 1 when the fetch was accepted, T5 and T6 follow T4. req_long has no effect on non-fetch kinds.
- R9: At the clock edge ending T3 of a fetch or read, rdata takes the value of ad_i. It then holds until the next such edge.
- R10: busy is 1 from T1 through the last T-state. done is 1 for exactly the one cycle after the last T-state.
- R11: req_kind uses these codes: 0 fetch, 1 memory read, 2 memory write, 3 IO read, 4 IO write. A request with a known code that is present while idle starts T1 on the next cycle. Codes 5 to 7 are never accepted, and requests made while busy have no effect.
- R12: Reset leaves the block in this state: idle, ale 0, rd_n 1, wr_n 1, ad_oe 0, status 2'b00, io_m 0, done 0, busy 0, rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cycle request strobe |
| req_kind | input | 3 | Cycle kind code |
| req_long | input | 1 | Selects the long (6 T-state) fetch |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data byte |
| ready | input | 1 | Memory/IO ready, sampled in T2 and wait states |
| ad_i | input | 8 | Shared bus input side |
| ad_o | output | 8 | Shared bus output side (address low / write data) |
| ad_oe | output | 1 | Shared bus output enable |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for IO cycles, 0 for memory cycles |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte captured at the end of T3 |

## Verification
The assertions take for granted that ready and req_valid carry known 0/1 values at every rising edge. They also assume that nothing drives ad_i in a way that matters except in T3 of a read. The bench drives every input half a cycle away from the sampling edge. It sets ready low only in T2 and wait states, for a counted number of cycles per transaction. It places the expected byte on ad_i only in T3 and unrelated bytes elsewhere. Stray requests, including unknown kind codes and requests made while busy, are issued only at points where the block must ignore them.

// File: rtl/bcyc_pkg.sv
`timescale 1ns/1ps
package bcyc_pkg;

    typedef enum logic [2:0] {
        KIND_FETCH  = 3'd0,
        KIND_MEM_RD = 3'd1,
        KIND_MEM_WR = 3'd2,
        KIND_IO_RD  = 3'd3,
        KIND_IO_WR  = 3'd4
    } kind_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_TW   = 3'd3,
        PH_T3   = 3'd4,
        PH_T4   = 3'd5,
        PH_T5   = 3'd6,
        PH_T6   = 3'd7
    } phase_e;

    localparam logic [1:0] STAT_HALT  = 2'b00;
    localparam logic [1:0] STAT_WRITE = 2'b01;
    localparam logic [1:0] STAT_READ  = 2'b10;
    localparam logic [1:0] STAT_FETCH = 2'b11;

    function automatic logic kind_known(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic is_write(input kind_e k);
        return (k == KIND_MEM_WR) || (k == KIND_IO_WR);
    endfunction

    function automatic logic is_io(input kind_e k);
        return (k == KIND_IO_RD) || (k == KIND_IO_WR);
    endfunction

    function automatic logic is_fetch(input kind_e k);
        return k == KIND_FETCH;
    endfunction

    function automatic logic [1:0] status_of(input kind_e k);
        logic [1:0] s;
        unique case (k)
            KIND_FETCH:              s = STAT_FETCH;
            KIND_MEM_RD, KIND_IO_RD: s = STAT_READ;
            KIND_MEM_WR, KIND_IO_WR: s = STAT_WRITE;
            default:                 s = STAT_HALT;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bcyc_seq.sv
`timescale 1ns/1ps
module bcyc_seq
    import bcyc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic              req_long,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    output phase_e            phase,
    output kind_e             kind_q,
    output logic              long_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              done,
    output logic              write_hold
);

    phase_e nxt;
    logic   accept;
    logic   last_t;

    assign accept = (phase == PH_IDLE) && req_valid && kind_known(req_kind);
    assign last_t = (phase != PH_IDLE) && (nxt == PH_IDLE);

    // next-state selection
    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE:      nxt = accept ? PH_T1 : PH_IDLE;
            PH_T1:        nxt = PH_T2;
            PH_T2, PH_TW: nxt = ready ? PH_T3 : PH_TW;
            PH_T3:        nxt = is_fetch(kind_q) ? PH_T4 : PH_IDLE;
            PH_T4:        nxt = long_q ? PH_T5 : PH_IDLE;
            PH_T5:        nxt = PH_T6;
            PH_T6:        nxt = PH_IDLE;
            default:      nxt = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= nxt;
    end

    // request capture and cycle-end flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q     <= KIND_FETCH;
            long_q     <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
            done       <= 1'b0;
            write_hold <= 1'b0;
        end else begin
            if (accept) begin
                kind_q  <= kind_e'(req_kind);
                long_q  <= req_long && (req_kind == KIND_FETCH);
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            done       <= last_t;
            write_hold <= (phase == PH_T3) && is_write(kind_q);
        end
    end

    a_r7_wait_on_low_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T2 || phase == PH_TW) && !ready) |=> (phase == PH_TW));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> ($stable(addr_q) && $stable(kind_q)));

    a_r8_long_order: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T5) |=> (phase == PH_T6));

endmodule

// File: rtl/bcyc_pins.sv
`timescale 1ns/1ps
module bcyc_pins
    import bcyc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  phase_e                   phase,
    input  kind_e                    kind_q,
    input  logic [ADDR_W-1:0]        addr_q,
    input  logic [DATA_W-1:0]        wdata_q,
    input  logic                     write_hold,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     io_m,
    output logic                     s1,
    output logic                     s0,
    output logic [DATA_W-1:0]        ad_o,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic       active;
    logic       strobe_win;
    logic [1:0] stat;

    // output decode from the current T-state
    always_comb begin
        active     = (phase != PH_IDLE);
        strobe_win = 1'b0;
        ale        = 1'b0;
        unique case (phase)
            PH_T1:               ale = 1'b1;
            PH_T2, PH_TW, PH_T3: strobe_win = 1'b1;
            default: ;
        endcase
        stat  = active ? status_of(kind_q) : STAT_HALT;
        s1    = stat[1];
        s0    = stat[0];
        io_m  = active && is_io(kind_q);
        rd_n  = !(strobe_win && !is_write(kind_q));
        wr_n  = !(strobe_win && is_write(kind_q));
        ad_oe = ale || (strobe_win && is_write(kind_q)) || write_hold;
        ad_o  = ale ? addr_q[DATA_W-1:0] : wdata_q;
        a_hi  = addr_q[ADDR_W-1:ADDR_W-HI_W];
    end

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    a_r6_write_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    a_r5_read_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

endmodule

// File: rtl/bcyc_capture.sv
`timescale 1ns/1ps
module bcyc_capture
    import bcyc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  kind_e             kind_q,
    input  logic [DATA_W-1:0] ad_i,
    output logic [DATA_W-1:0] rdata
);

    logic grab;
    assign grab = (phase == PH_T3) && !is_write(kind_q);

    always_ff @(posedge clk) begin
        if (!rst_n)    rdata <= '0;
        else if (grab) rdata <= ad_i;
    end

    a_r9_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_T3) |=> $stable(rdata));

endmodule

// File: rtl/bus_cycle_engine.sv
`timescale 1ns/1ps
module bus_cycle_engine
    import bcyc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_kind,
    input  logic                     req_long,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     ready,
    input  logic [DATA_W-1:0]        ad_i,
    output logic [DATA_W-1:0]        ad_o,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     io_m,
    output logic                     s1,
    output logic                     s0,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata
);

    phase_e            phase;
    kind_e             kind_q;
    logic              long_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_hold;

    bcyc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_long   (req_long),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ready      (ready),
        .phase      (phase),
        .kind_q     (kind_q),
        .long_q     (long_q),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .done       (done),
        .write_hold (write_hold)
    );

    bcyc_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .kind_q     (kind_q),
        .addr_q     (addr_q),
        .wdata_q    (wdata_q),
        .write_hold (write_hold),
        .ale        (ale),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .io_m       (io_m),
        .s1         (s1),
        .s0         (s0),
        .ad_o       (ad_o),
        .ad_oe      (ad_oe),
        .a_hi       (a_hi)
    );

    bcyc_capture #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .kind_q(kind_q),
        .ad_i  (ad_i),
        .rdata (rdata)
    );

    assign busy = (phase != PH_IDLE);

    a_r1_idle_status: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ({s1, s0} == 2'b00 && !io_m && rd_n && wr_n));

    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r8_fetch_t4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && {s1, s0} == 2'b11 && $past(!rd_n) && rd_n) |-> !ad_oe);

endmodule

// File: tb/bus_cycle_engine_bench.sv
`timescale 1ns/1ps
module bus_cycle_engine_bench;

    localparam int P_IDLE = 0, P_T1 = 1, P_T2 = 2, P_W = 3, P_T3 = 4,
                   P_T4 = 5, P_T5 = 6, P_T6 = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic        req_long = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        ready = 1'b1;
    logic [7:0]  ad_i = 8'h0;
    logic [7:0]  ad_o;
    logic        ad_oe;
    logic [7:0]  a_hi;
    logic        ale, rd_n, wr_n, io_m, s1, s0, busy, done;
    logic [7:0]  rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // behavioural model state
    int          ph = P_IDLE;
    int          rest[$];
    int          waited = 0;
    int          cur_waits = 0;
    int          m_waits = 0;
    int          m_kind = 0;
    logic [15:0] m_addr = 16'h0;
    logic [7:0]  m_wdata = 8'h0;
    bit          exp_done = 1'b0;
    bit          exp_hold = 1'b0;
    logic [7:0]  exp_rdata = 8'h0;

    always #4 clk = ~clk;

    bus_cycle_engine u_bus_cycle_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_long(req_long), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .a_hi(a_hi),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0),
        .busy(busy), .done(done), .rdata(rdata)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input string req, input string sig,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, sig, act, exp, $time);
        end
    endtask

    function automatic bit k_write(input int k); return k == 2 || k == 4; endfunction
    function automatic bit k_io(input int k);    return k == 3 || k == 4; endfunction

    // per-cycle comparison and model advance, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            ph = P_IDLE; rest.delete(); exp_done = 0; exp_hold = 0; exp_rdata = 8'h0;
            ready = 1'b1;
            chk("R12", "ale", {15'b0, ale}, 16'd0);
            chk("R12", "rd_n/wr_n", {14'b0, rd_n, wr_n}, 16'd3);
            chk("R12", "ad_oe", {15'b0, ad_oe}, 16'd0);
            chk("R12", "status/io_m", {13'b0, s1, s0, io_m}, 16'd0);
            chk("R12", "busy/done", {14'b0, busy, done}, 16'd0);
            chk("R12", "rdata", {8'b0, rdata}, 16'd0);
        end else begin : cmp
            bit act, strb, wr, oe_exp;
            logic [1:0] st;
            act  = (ph != P_IDLE);
            strb = (ph == P_T2 || ph == P_W || ph == P_T3);
            wr   = k_write(m_kind);
            st   = !act ? 2'b00 : (m_kind == 0) ? 2'b11 : wr ? 2'b01 : 2'b10;
            chk("R1", "status", {14'b0, s1, s0}, {14'b0, st});
            chk("R2", "io_m", {15'b0, io_m}, {15'b0, act && k_io(m_kind)});
            chk("R3", "ale", {15'b0, ale}, {15'b0, ph == P_T1});
            if (ph == P_T1) chk("R3", "ad_o addr", {8'b0, ad_o}, {8'b0, m_addr[7:0]});
            if (act) chk("R4", "a_hi", {8'b0, a_hi}, {8'b0, m_addr[15:8]});
            chk("R5", "rd_n", {15'b0, rd_n}, {15'b0, !(strb && !wr)});
            chk("R6", "wr_n", {15'b0, wr_n}, {15'b0, !(strb && wr)});
            oe_exp = (ph == P_T1) || (strb && wr) || exp_hold;
            chk(wr ? "R6" : "R5", "ad_oe", {15'b0, ad_oe}, {15'b0, oe_exp});
            if (oe_exp && ph != P_T1) chk("R6", "ad_o data", {8'b0, ad_o}, {8'b0, m_wdata});
            chk("R10", "busy", {15'b0, busy}, {15'b0, act});
            chk("R10", "done", {15'b0, done}, {15'b0, exp_done});
            chk("R9", "rdata", {8'b0, rdata}, {8'b0, exp_rdata});

            // inputs for this cycle
            ready = !((ph == P_T2 || ph == P_W) && waited < m_waits);
            ad_i  = (ph == P_T3) ? mem_byte(m_addr) : ~mem_byte(m_addr) ^ 8'h3C;

            // advance
            exp_done = 0; exp_hold = 0;
            if (ph == P_T3 && !wr) exp_rdata = ad_i;
            if (ph == P_IDLE) begin
                if (req_valid && req_kind <= 3'd4) begin
                    m_kind = int'(req_kind); m_addr = req_addr; m_wdata = req_wdata;
                    m_waits = cur_waits; waited = 0;
                    rest = '{P_T2, P_T3};
                    if (m_kind == 0) begin
                        rest.push_back(P_T4);
                        if (req_long) begin rest.push_back(P_T5); rest.push_back(P_T6); end
                    end
                    ph = P_T1;
                end
            end else if ((ph == P_T2 || ph == P_W) && !ready) begin
                ph = P_W; waited++;
            end else if (rest.size() == 0) begin
                exp_done = 1; exp_hold = (ph == P_T3) && wr; ph = P_IDLE;
            end else begin
                ph = rest.pop_front();
            end
        end
    end

    task automatic issue(input logic [2:0] k, input bit lng, input logic [15:0] a,
                         input logic [7:0] d, input int w, input bit noisy);
        do begin @(posedge clk); #1; end while (ph != P_IDLE);
        req_kind = k; req_long = lng; req_addr = a; req_wdata = d;
        cur_waits = w; req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (noisy) begin
            // R11: a request during T1 must change nothing
            req_kind = 3'd2; req_addr = 16'hFFFF; req_wdata = 8'hEE; req_valid = 1'b1;
            @(posedge clk); #1;
            req_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        issue(3'd0, 1'b0, 16'h1234, 8'h00, 0, 1'b0); // R8 short fetch
        issue(3'd0, 1'b1, 16'hABCD, 8'h00, 2, 1'b0); // R8 long fetch, R7 waits
        issue(3'd1, 1'b0, 16'h2000, 8'h00, 0, 1'b0); // R5 memory read
        issue(3'd2, 1'b0, 16'h3001, 8'h5C, 1, 1'b0); // R6 memory write
        issue(3'd3, 1'b0, 16'h0042, 8'h00, 3, 1'b0); // R2 IO read, R7
        issue(3'd4, 1'b0, 16'h00F0, 8'hA7, 0, 1'b0); // R2 IO write
        issue(3'd1, 1'b0, 16'h7F80, 8'h00, 0, 1'b0); // R6 hold then back-to-back read
        issue(3'd2, 1'b1, 16'h4455, 8'h19, 0, 1'b0); // R8 long ignored on write
        issue(3'd5, 1'b0, 16'h5555, 8'h00, 0, 1'b0); // R11 unknown code rejected
        repeat (2) @(posedge clk);
        #1 chk("R11", "busy after unknown code", {15'b0, busy}, 16'd0);
        issue(3'd0, 1'b0, 16'hC0DE, 8'h00, 1, 1'b1); // R11 request while busy
        issue(3'd3, 1'b0, 16'h0099, 8'h00, 0, 1'b0);
        repeat (8) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; failures++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule